// File: doc/BRIEF.md
# Antisymmetric FIR Hilbert Transformer

The block turns a stream of real, signed two's-complement samples into an analytic-signal pair. The imaginary output is a short odd-length FIR approximation of the Hilbert transform. The real output is the middle sample of the same window, carried through the same pipeline so that both outputs describe one instant. A typical use is envelope or phase extraction: a magnitude or angle stage downstream consumes the pair.

The Hilbert kernel is antisymmetric and has zeros at every even offset. Each odd offset j therefore contributes one product, coefficient c_j times (older sample minus newer sample). The subtraction happens before the multiply, so one multiplier serves each mirrored pair of nonzero taps. An input valid strobe moves the sample window forward. The strobe travels down the pipeline and marks both outputs valid in the same cycle.

Top module: `hilb_xform`

## Requirements
- R1: A sample presented with `in_valid` high at a rising clock edge produces exactly one `out_valid` pulse 4 clock cycles later. `out_valid` is never high in any other cycle.
- R2: The window advances only on accepted samples. Idle cycles between samples do not change any later output value.
- R3: Let s0 be the newest accepted sample and s14 the oldest (HALF = 7, centre s7). Let S = sum over j in {1,3,5,7} of c_j*(s(7+j) - s(7-j)), with c_j = round(1024/(j*pi)), that is 326, 109, 65 and 47. Then `out_imag` is floor(S/512), read as 11-bit two's complement.
- R4: `out_real` is the centre sample s7, sign-extended from 10 to 11 bits.
- R5: When floor(S/512) lies outside the 11-bit range, `out_imag` saturates to 1023 or -1024.
- R6: A window that holds 15 equal samples gives `out_imag` = 0.
- R7: For a cosine input of amplitude 400 and period 10.3 samples, `out_imag` stays within 25 of 400*sin at the phase of the centre sample.
- R8: While reset is high (synchronous, active high), `out_valid`, `out_real` and `out_imag` are 0 and the window is cleared to zero samples.
- R9: In a cycle where `out_valid` is low, `out_real` and `out_imag` keep the values they had in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept `in_sample` this cycle |
| in_sample | input | IN_W (10) | Signed input sample |
| out_valid | output | 1 | Both outputs carry a new pair |
| out_real | output | OUT_W (11) | Delay-matched centre sample |
| out_imag | output | OUT_W (11) | Hilbert FIR output, saturated |

## Verification
A corrupted window register shows as an `out_imag` error on the next output pulse. The error persists until that sample has left all 15 window positions. A wrong entry at the centre position also shows immediately on `out_real`. A broken valid stage shows within 4 cycles as a missing, extra or misplaced `out_valid` pulse. A pipeline register that loads during an idle cycle shows at once as an output change while `out_valid` is low. Coefficient or sign errors show on the first nonzero pair difference, and as a gain or phase error against the sine reference on the cosine run.

// File: rtl/hilb_pkg.sv
package hilb_pkg;

   localparam real HILB_PI = 3.141592653589793;

   // Rounded magnitude of 2*scale/(off*pi) for an odd offset
   function automatic int tap_coef(input int off, input int scale);
      real mag;
      mag = (2.0 * scale) / (off * HILB_PI);
      return $rtoi(mag + 0.5);
   endfunction

   // Number of nonzero taps on one side of the centre
   function automatic int nz_taps(input int half);
      return (half + 1) / 2;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/hilb_window.sv
// Sample window: a shift chain that advances only on accepted samples.
// Exposes the mirrored pairs at odd offsets and the centre slot.
module hilb_window #(
   parameter int IN_W = 10,
   parameter int HALF = 7,
   localparam int DEPTH = 2 * HALF + 1,
   localparam int NT    = hilb_pkg::nz_taps(HALF)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 shift_en,
   input  logic [IN_W-1:0]      din,
   output logic [NT*IN_W-1:0]   older_flat,
   output logic [NT*IN_W-1:0]   newer_flat,
   output logic [IN_W-1:0]      mid
);

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stg
         logic [IN_W-1:0] q;
         if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst)           q <= '0;
               else if (shift_en) q <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (rst)           q <= '0;
               else if (shift_en) q <= g_stg[i-1].q;
            end
         end
      end

      for (genvar k = 0; k < NT; k++) begin : g_pair
         localparam int OFF = 2 * k + 1;
         assign older_flat[k*IN_W +: IN_W] = g_stg[HALF+OFF].q;
         assign newer_flat[k*IN_W +: IN_W] = g_stg[HALF-OFF].q;
      end
   endgenerate

   assign mid = g_stg[HALF].q;

endmodule

// File: rtl/hilb_presub.sv
// Pre-subtraction stage: older minus newer per odd offset, one bit wider.
module hilb_presub #(
   parameter int IN_W = 10,
   parameter int NT   = 4,
   localparam int DW  = IN_W + 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic [NT*IN_W-1:0]  older_flat,
   input  logic [NT*IN_W-1:0]  newer_flat,
   input  logic [IN_W-1:0]     mid_in,
   output logic [NT*DW-1:0]    diff_flat,
   output logic [IN_W-1:0]     mid_out
);

   generate
      for (genvar k = 0; k < NT; k++) begin : g_sub
         logic [IN_W-1:0] o_s, n_s;
         logic [DW-1:0]   d;
         assign o_s = older_flat[k*IN_W +: IN_W];
         assign n_s = newer_flat[k*IN_W +: IN_W];
         always_ff @(posedge clk) begin
            if (rst)     d <= '0;
            else if (en) d <= {o_s[IN_W-1], o_s} - {n_s[IN_W-1], n_s};
         end
         assign diff_flat[k*DW +: DW] = d;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)     mid_out <= '0;
      else if (en) mid_out <= mid_in;
   end

endmodule

// File: rtl/hilb_mac.sv
// One constant multiplier per nonzero tap, then sum, scale and limit.
module hilb_mac #(
   parameter int DW       = 11,
   parameter int HALF     = 7,
   parameter int CW       = 10,
   parameter int SCALE    = 512,
   parameter int OUT_W    = 11,
   parameter bit SATURATE = 1'b1,
   localparam int NT    = hilb_pkg::nz_taps(HALF),
   localparam int PW    = DW + CW,
   localparam int SW    = PW + $clog2(NT) + 1,
   localparam int SHIFT = $clog2(SCALE)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mul_en,
   input  logic              out_en,
   input  logic [NT*DW-1:0]  diff_flat,
   output logic [OUT_W-1:0]  imag
);

   localparam logic signed [SW-1:0] SAT_HI = SW'(2 ** (OUT_W - 1) - 1);
   localparam logic signed [SW-1:0] SAT_LO = ~SAT_HI;

   logic [NT*PW-1:0]      prod_flat;
   logic signed [SW-1:0]  acc;
   logic signed [SW-1:0]  scaled;
   logic [OUT_W-1:0]      imag_n;

   generate
      for (genvar k = 0; k < NT; k++) begin : g_tap
         localparam int CVAL = hilb_pkg::tap_coef(2 * k + 1, SCALE);
         localparam logic signed [CW-1:0] COEF = CW'(CVAL);
         logic signed [DW-1:0] d_s;
         logic signed [PW-1:0] p;
         assign d_s = signed'(diff_flat[k*DW +: DW]);
         always_ff @(posedge clk) begin
            if (rst)         p <= '0;
            else if (mul_en) p <= PW'(d_s) * PW'(COEF);
         end
         assign prod_flat[k*PW +: PW] = p;
      end
   endgenerate

   always_comb begin
      acc = '0;
      for (int k = 0; k < NT; k++) begin
         acc = acc + SW'(signed'(prod_flat[k*PW +: PW]));
      end
      scaled = acc >>> SHIFT;
   end

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (scaled > SAT_HI)      imag_n = SAT_HI[OUT_W-1:0];
            else if (scaled < SAT_LO) imag_n = SAT_LO[OUT_W-1:0];
            else                      imag_n = scaled[OUT_W-1:0];
         end
      end else begin : g_wrap
         assign imag_n = scaled[OUT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)         imag <= '0;
      else if (out_en) imag <= imag_n;
   end

endmodule

// File: rtl/hilb_xform.sv
// Analytic-signal generator: delay-matched real path and Hilbert FIR path.
module hilb_xform #(
   parameter int IN_W     = 10,
   parameter int OUT_W    = 11,
   parameter int HALF     = 7,
   parameter int COEF_W   = 10,
   parameter int SCALE    = 512,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [IN_W-1:0]   in_sample,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_real,
   output logic [OUT_W-1:0]  out_imag
);

   localparam int NT = hilb_pkg::nz_taps(HALF);
   localparam int DW = IN_W + 1;

   generate
      if ((HALF < 1) || (HALF % 2 == 0)) begin : g_bad_half
         $error("hilb_xform: HALF must be odd and positive");
      end
      if (!hilb_pkg::is_pow2(SCALE)) begin : g_bad_scale
         $error("hilb_xform: SCALE must be a power of two");
      end
      if (OUT_W <= IN_W) begin : g_bad_out
         $error("hilb_xform: OUT_W must exceed IN_W");
      end
      if (hilb_pkg::tap_coef(1, SCALE) >= 2 ** (COEF_W - 1)) begin : g_bad_coef
         $error("hilb_xform: COEF_W too narrow for the largest tap");
      end
   endgenerate

   logic                v_win, v_sub, v_mul;
   logic [NT*IN_W-1:0]  older_flat, newer_flat;
   logic [IN_W-1:0]     mid_win, mid_sub, mid_mul;
   logic [NT*DW-1:0]    diff_flat;

   always_ff @(posedge clk) begin
      if (rst) begin
         v_win     <= 1'b0;
         v_sub     <= 1'b0;
         v_mul     <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         v_win     <= in_valid;
         v_sub     <= v_win;
         v_mul     <= v_sub;
         out_valid <= v_mul;
      end
   end

   hilb_window #(.IN_W(IN_W), .HALF(HALF)) u_win (
      .clk        (clk),
      .rst        (rst),
      .shift_en   (in_valid),
      .din        (in_sample),
      .older_flat (older_flat),
      .newer_flat (newer_flat),
      .mid        (mid_win)
   );

   hilb_presub #(.IN_W(IN_W), .NT(NT)) u_sub (
      .clk        (clk),
      .rst        (rst),
      .en         (v_win),
      .older_flat (older_flat),
      .newer_flat (newer_flat),
      .mid_in     (mid_win),
      .diff_flat  (diff_flat),
      .mid_out    (mid_sub)
   );

   hilb_mac #(
      .DW(DW), .HALF(HALF), .CW(COEF_W), .SCALE(SCALE),
      .OUT_W(OUT_W), .SATURATE(SATURATE)
   ) u_mac (
      .clk       (clk),
      .rst       (rst),
      .mul_en    (v_sub),
      .out_en    (v_mul),
      .diff_flat (diff_flat),
      .imag      (out_imag)
   );

   // Real path: centre sample carried alongside the multiply and sum stages
   always_ff @(posedge clk) begin
      if (rst) begin
         mid_mul  <= '0;
         out_real <= '0;
      end else begin
         if (v_sub) mid_mul  <= mid_sub;
         if (v_mul) out_real <= {{(OUT_W-IN_W){mid_mul[IN_W-1]}}, mid_mul};
      end
   end

endmodule

// File: rtl/hilb_xform_chk.sv
module hilb_xform_chk #(
   parameter int IN_W  = 10,
   parameter int OUT_W = 11
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              out_valid,
   input logic [OUT_W-1:0]  out_real,
   input logic [OUT_W-1:0]  out_imag
);

   localparam int EXT = OUT_W - IN_W + 1;

   logic [2:0] age;
   logic       rst_q;
   logic [EXT-1:0] real_top;

   assign real_top = out_real[OUT_W-1:IN_W-1];

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst)             age <= '0;
      else if (age != 3'd7) age <= age + 3'd1;
   end

   AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
      (age >= 3'd4) |-> (out_valid == $past(in_valid, 4)));  // R1

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      ((age >= 3'd1) && !out_valid) |-> ($stable(out_real) && $stable(out_imag)));  // R9

   AST_REAL_SEXT: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (($countones(real_top) == 0) || ($countones(real_top) == EXT)));  // R4

   always @(posedge clk) begin
      if (rst_q === 1'b1) begin
         AST_RESET_CLEAR: assert (!out_valid && (out_real == '0) && (out_imag == '0));  // R8
      end
   end

endmodule

bind hilb_xform hilb_xform_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_real  (out_real),
   .out_imag  (out_imag)
);

// File: tb/sim_hilb_xform.sv
`timescale 1ns/1ps
module sim_hilb_xform;

   localparam int IN_W  = 10;
   localparam int OUT_W = 11;
   localparam int HALF  = 7;
   localparam int DEPTH = 2 * HALF + 1;
   localparam int SHIFT = 9;
   localparam int LAT   = 4;
   localparam int TOL   = 25;
   localparam int WD    = 200000;

   typedef struct {
      int    due;
      int    re;
      int    im;
      bit    after_gap;
      bit    has_fix;
      int    fix;
      string ftag;
      bit    has_ref;
      int    refv;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             in_valid = 1'b0;
   logic [IN_W-1:0]  in_sample = '0;
   logic             out_valid;
   logic [OUT_W-1:0] out_real, out_imag;

   hilb_xform u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(out_valid), .out_real(out_real), .out_imag(out_imag)
   );

   always #10 clk = ~clk;

   int   n_chk = 0, n_bad = 0, cyc = 0;
   int   win [DEPTH];
   exp_t q [$];
   int   last_re = 0, last_im = 0;
   bit   gap_seen = 1'b0;
   bit   done = 1'b0;

   function automatic int sx(input logic [OUT_W-1:0] v);
      return int'(signed'(v));
   endfunction

   function automatic int ref_coef(input int off);
      real m;
      m = 1024.0 / (off * 3.141592653589793);
      return $rtoi(m + 0.5);
   endfunction

   function automatic int ref_imag();
      int s;
      s = 0;
      for (int j = 1; j <= HALF; j += 2)
         s += ref_coef(j) * (win[HALF+j] - win[HALF-j]);
      s = s >>> SHIFT;
      if (s > 1023)  s = 1023;
      if (s < -1024) s = -1024;
      return s;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic observe();
      if (rst) return;
      if (out_valid) begin
         if (q.size() != 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            chk(1'b1, "R1", cyc, e.due);
            chk(sx(out_real) == e.re, "R4", sx(out_real), e.re);
            chk(sx(out_imag) == e.im, e.after_gap ? "R2" : "R3", sx(out_imag), e.im);
            if (e.has_fix) chk(sx(out_imag) == e.fix, e.ftag, sx(out_imag), e.fix);
            if (e.has_ref)
               chk((sx(out_imag) - e.refv <= TOL) && (e.refv - sx(out_imag) <= TOL),
                   "R7", sx(out_imag), e.refv);
         end else begin
            chk(1'b0, "R1", 1, 0);
         end
         last_re = sx(out_real);
         last_im = sx(out_imag);
      end else begin
         if (q.size() != 0 && q[0].due == cyc) begin
            chk(1'b0, "R1", 0, 1);
            void'(q.pop_front());
         end
         chk(sx(out_real) == last_re && sx(out_imag) == last_im, "R9",
             sx(out_imag), last_im);
      end
   endtask

   task automatic step(input bit v, input int x,
                       input bit has_fix = 1'b0, input int fix = 0, input string ftag = "",
                       input bit has_ref = 1'b0, input int refv = 0);
      exp_t e;
      @(negedge clk);
      cyc++;
      observe();
      in_valid  = v;
      in_sample = x[IN_W-1:0];
      if (v) begin
         for (int i = DEPTH - 1; i > 0; i--) win[i] = win[i-1];
         win[0]      = x;
         e.due       = cyc + LAT;
         e.re        = win[HALF];
         e.im        = ref_imag();
         e.after_gap = gap_seen;
         e.has_fix   = has_fix;
         e.fix       = fix;
         e.ftag      = ftag;
         e.has_ref   = has_ref;
         e.refv      = refv;
         q.push_back(e);
         gap_seen = 1'b0;
      end else begin
         gap_seen = 1'b1;
      end
   endtask

   task automatic check_reset_state();
      chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
      chk(sx(out_real) == 0, "R8", sx(out_real), 0);
      chk(sx(out_imag) == 0, "R8", sx(out_imag), 0);
   endtask

   task automatic clear_model();
      for (int i = 0; i < DEPTH; i++) win[i] = 0;
      q.delete();
      last_re  = 0;
      last_im  = 0;
      gap_seen = 1'b0;
   endtask

   initial begin
      #(20 * WD);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int m;
      void'($urandom(32'd4711));
      clear_model();
      repeat (3) begin @(negedge clk); cyc++; end
      check_reset_state();
      rst = 1'b0;

      // Reset cleared the window: early outputs include zero samples (R8)
      for (int i = 0; i < 5; i++) step(1'b1, 100 + 10 * i);

      // Random samples with random gaps (R2, R3, R4)
      for (int i = 0; i < 300; i++)
         step(($urandom % 4) != 0, int'($urandom % 1024) - 512);

      // Constant window gives zero (R6)
      for (int i = 0; i < 20; i++) step(1'b1, 300, i >= 14, 0, "R6");

      // Positive saturation (R5): older half high, newer half low
      for (int i = 0; i < 7; i++) step(1'b1, 511);
      step(1'b1, 0);
      for (int i = 0; i < 7; i++) step(1'b1, -512, i == 6, 1023, "R5");
      step(1'b0, 0);
      // Negative saturation (R5)
      for (int i = 0; i < 7; i++) step(1'b1, -512);
      step(1'b1, 0);
      for (int i = 0; i < 7; i++) step(1'b1, 511, i == 6, -1024, "R5");

      // Cosine in, sine out, with idle gaps (R7, R2)
      m = 0;
      for (int it = 0; m < 120; it++) begin
         if (it % 4 == 3) begin
            step(1'b0, 0);
         end else begin
            int xs, rs;
            xs = int'(400.0 * $cos(2.0 * 3.141592653589793 * m / 10.3));
            rs = int'(400.0 * $sin(2.0 * 3.141592653589793 * (m - HALF) / 10.3));
            step(1'b1, xs, 1'b0, 0, "", m >= DEPTH - 1, rs);
            m++;
         end
      end
      repeat (8) step(1'b0, 0);

      // Mid-run reset clears outputs and window (R8)
      @(negedge clk); cyc++; observe();
      rst = 1'b1;
      in_valid = 1'b0;
      @(negedge clk); cyc++;
      check_reset_state();
      @(negedge clk); cyc++;
      clear_model();
      rst = 1'b0;
      for (int i = 0; i < 3; i++) step(1'b1, -200);
      repeat (8) step(1'b0, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule